// File: doc/BRIEF.md
# RMII Receive Byte Aligner

This block terminates the receive half of a reduced media-independent interface. It takes a carrier/data-valid line and a two-bit data bus, both sampled on one shared 50 MHz reference clock. It packs the di-bits into bytes and searches the incoming stream for the start-of-frame delimiter. Everything seen before the delimiter is discarded. The bytes that follow are presented on a simple buffer write port, with a marker on the first byte and a separate end-of-frame pulse.

A static rate input selects the line speed. At 100 Mb/s every clock edge carries a new di-bit. At 10 Mb/s each di-bit is held for ten clocks, and the block takes one sample per ten-clock window at a fixed offset from the carrier rising edge. Frame entry is gated by the carrier line, and so is frame exit. A frame ends only after two consecutive low carrier samples, so a single low sample inside a frame is skipped. A frame that stops partway through a byte is closed with a truncation flag.

Top module: `rmii_rx_align`

## Requirements
- R1: While rst_ni is low, wr_valid_o, wr_sof_o, wr_eof_o and wr_trunc_o are all 0.
- R2: With speed10_i = 0, rxd_i is taken as one di-bit at every clock edge. The first di-bit after the delimiter, and the first di-bit of each later byte, lands in bits [1:0] of wr_data_o, and the fourth lands in bits [7:6].
- R3: The delimiter is the di-bit run 01, 01, 01, 11 (byte value 0xD5 once packed). Preamble di-bits and the delimiter itself are never written out. The first byte after the delimiter carries wr_sof_o = 1, and wr_sof_o is only ever high together with wr_valid_o.
- R4: wr_valid_o is a one-cycle pulse. At 100 Mb/s it is high in the cycle after the clock edge that follows the edge sampling the byte's fourth di-bit.
- R5: With speed10_i = 1, each di-bit lasts ten clocks. The block samples crs_dv_i and rxd_i once per window, five clock edges after the edge where crs_dv_i is first seen high while idle. Values outside that sample point have no effect.
- R6: Inside a frame, one low crs_dv_i sample is skipped and is not taken as data. Two consecutive low samples end the frame, which raises wr_eof_o for one cycle with wr_valid_o low. This holds even when no byte followed the delimiter.
- R7: If the frame ends with one to three di-bits of an unfinished byte, those di-bits are not written out, and wr_trunc_o = 1 in the wr_eof_o cycle. Otherwise wr_trunc_o stays 0.
- R8: A low crs_dv_i sample before the delimiter is complete drops the frame attempt and clears the delimiter search. No byte and no wr_eof_o follow from that attempt.
- R9: Payload bytes equal to 0xD5 or 0x55 are written as data and do not restart alignment. wr_sof_o marks only the first byte of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed10_i | input | 1 | 1 selects 10 Mb/s sampling, 0 selects 100 Mb/s |
| crs_dv_i | input | 1 | Carrier sense / receive data valid |
| rxd_i | input | 2 | Receive di-bit |
| wr_valid_o | output | 1 | Byte write strobe, one cycle |
| wr_data_o | output | 8 | Assembled byte |
| wr_sof_o | output | 1 | First byte of frame, with wr_valid_o |
| wr_eof_o | output | 1 | End-of-frame pulse |
| wr_trunc_o | output | 1 | Frame ended mid-byte, with wr_eof_o |

## Verification
A wrong byte phase after the delimiter shows on the very first write as a byte whose di-bits are rotated. A stale delimiter history shows as bytes appearing after a failed start, or as a missing start. A sampling counter locked to the wrong phase in 10 Mb/s mode picks up the corrupted edges of each di-bit window, so the delimiter is never matched, or the payload comes out altered within the first ten-clock window. Mishandling of the low-carrier count appears one di-bit period after the gap: either a premature end-of-frame pulse with bytes lost afterwards, or a frame that never closes.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int unsigned DIBIT_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rmii_rx_sampler.sv
module rmii_rx_sampler
  import rmii_rx_pkg::*;
#(
  parameter int unsigned DIV   = 10,
  parameter int unsigned PHASE = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               speed10_i,
  input  logic               crs_dv_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  input  logic               idle_i,
  output logic               samp_stb_o,
  output logic               samp_crs_o,
  output logic [DIBIT_W-1:0] samp_rxd_o
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(DIV - 1);
  localparam logic [CNT_W-1:0] CNT_PHASE = CNT_W'(PHASE);

  logic               crs_q;
  logic [DIBIT_W-1:0] rxd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               rise;

  // restart window phase only on a fresh carrier while no frame is open
  assign rise = crs_dv_i & ~crs_q & idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      crs_q <= crs_dv_i;
      rxd_q <= rxd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rise) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign samp_stb_o = speed10_i ? (cnt_q == CNT_PHASE) : 1'b1;
  assign samp_crs_o = crs_q;
  assign samp_rxd_o = rxd_q;
endmodule

// File: rtl/rmii_rx_sfd_hunt.sv
module rmii_rx_sfd_hunt
  import rmii_rx_pkg::*;
#(
  parameter int unsigned         BYTE_W = 8,
  parameter logic [BYTE_W-1:0]   SFD    = 8'hD5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic               crs_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  output logic               idle_o,
  output logic               start_o,
  output logic               dibit_vld_o,
  output logic               end_o
);
  rx_state_e         state_q;
  logic [BYTE_W-1:0] hist_q;
  logic [BYTE_W-1:0] hist_nxt;
  logic              low_q;

  // newest di-bit enters at the top, so the first one ends in [1:0]
  assign hist_nxt = {rxd_i, hist_q[BYTE_W-1:DIBIT_W]};

  assign idle_o      = (state_q == ST_IDLE);
  assign start_o     = stb_i & crs_i & (state_q == ST_HUNT) & (hist_nxt == SFD);
  assign dibit_vld_o = stb_i & crs_i & (state_q == ST_DATA);
  assign end_o       = stb_i & ~crs_i & low_q & (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hist_q  <= '0;
      low_q   <= 1'b0;
    end else if (stb_i) begin
      unique case (state_q)
        ST_IDLE: begin
          low_q <= 1'b0;
          if (crs_i) begin
            hist_q  <= hist_nxt;
            state_q <= ST_HUNT;
          end else begin
            hist_q <= '0;
          end
        end
        ST_HUNT: begin
          if (!crs_i) begin
            hist_q  <= '0;
            state_q <= ST_IDLE;
          end else if (hist_nxt == SFD) begin
            hist_q  <= '0;
            low_q   <= 1'b0;
            state_q <= ST_DATA;
          end else begin
            hist_q <= hist_nxt;
          end
        end
        ST_DATA: begin
          if (crs_i) begin
            low_q <= 1'b0;
          end else if (low_q) begin
            low_q   <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            low_q <= 1'b1;
          end
        end
        default: begin
          hist_q  <= '0;
          low_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer
  import rmii_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               dibit_vld_i,
  input  logic               end_i,
  input  logic [DIBIT_W-1:0] rxd_i,
  output logic               wr_valid_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_sof_o,
  output logic               wr_eof_o,
  output logic               wr_trunc_o
);
  localparam int unsigned NDIB  = BYTE_W / DIBIT_W;
  localparam int unsigned POS_W = (NDIB > 1) ? $clog2(NDIB) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(NDIB - 1);

  logic [POS_W-1:0]  pos_q;
  logic              first_q;
  logic [BYTE_W-1:0] byte_w;

  // one holding lane per di-bit slot except the last, which is taken live
  for (genvar i = 0; i < NDIB - 1; i++) begin : g_lane
    logic [DIBIT_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (dibit_vld_i && (pos_q == POS_W'(i))) begin
        lane_q <= rxd_i;
      end
    end
    assign byte_w[i*DIBIT_W +: DIBIT_W] = lane_q;
  end
  assign byte_w[BYTE_W-1 -: DIBIT_W] = rxd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      first_q    <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      wr_sof_o   <= 1'b0;
      wr_eof_o   <= 1'b0;
      wr_trunc_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      wr_sof_o   <= 1'b0;
      wr_eof_o   <= 1'b0;
      wr_trunc_o <= 1'b0;
      if (start_i) begin
        pos_q   <= '0;
        first_q <= 1'b1;
      end else if (dibit_vld_i) begin
        if (pos_q == POS_LAST) begin
          pos_q      <= '0;
          wr_valid_o <= 1'b1;
          wr_data_o  <= byte_w;
          wr_sof_o   <= first_q;
          first_q    <= 1'b0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else if (end_i) begin
        wr_eof_o   <= 1'b1;
        wr_trunc_o <= (pos_q != '0);
        pos_q      <= '0;
        first_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_align.sv
module rmii_rx_align
  import rmii_rx_pkg::*;
#(
  parameter int unsigned       BYTE_W = 8,
  parameter int unsigned       DIV    = 10,
  parameter int unsigned       PHASE  = 5,
  parameter logic [BYTE_W-1:0] SFD    = 8'hD5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed10_i,
  input  logic              crs_dv_i,
  input  logic [1:0]        rxd_i,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_sof_o,
  output logic              wr_eof_o,
  output logic              wr_trunc_o
);
  logic               samp_stb;
  logic               samp_crs;
  logic [DIBIT_W-1:0] samp_rxd;
  logic               idle;
  logic               start;
  logic               dibit_vld;
  logic               frame_end;

  rmii_rx_sampler #(
    .DIV   (DIV),
    .PHASE (PHASE)
  ) i_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed10_i  (speed10_i),
    .crs_dv_i   (crs_dv_i),
    .rxd_i      (rxd_i),
    .idle_i     (idle),
    .samp_stb_o (samp_stb),
    .samp_crs_o (samp_crs),
    .samp_rxd_o (samp_rxd)
  );

  rmii_rx_sfd_hunt #(
    .BYTE_W (BYTE_W),
    .SFD    (SFD)
  ) i_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (samp_stb),
    .crs_i       (samp_crs),
    .rxd_i       (samp_rxd),
    .idle_o      (idle),
    .start_o     (start),
    .dibit_vld_o (dibit_vld),
    .end_o       (frame_end)
  );

  rmii_rx_packer #(
    .BYTE_W (BYTE_W)
  ) i_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .dibit_vld_i (dibit_vld),
    .end_i       (frame_end),
    .rxd_i       (samp_rxd),
    .wr_valid_o  (wr_valid_o),
    .wr_data_o   (wr_data_o),
    .wr_sof_o    (wr_sof_o),
    .wr_eof_o    (wr_eof_o),
    .wr_trunc_o  (wr_trunc_o)
  );
endmodule

// File: rtl/rmii_rx_align_chk.sv
module rmii_rx_align_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_valid_o,
  input logic wr_sof_o,
  input logic wr_eof_o,
  input logic wr_trunc_o
);
  p_sof_with_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sof_o |-> wr_valid_o);

  p_byte_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  p_eof_no_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eof_o |-> !wr_valid_o);

  p_eof_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_eof_o |=> !wr_eof_o);

  p_trunc_at_eof_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_trunc_o |-> wr_eof_o);
endmodule

bind rmii_rx_align rmii_rx_align_chk i_chk (.*);

// File: tb/test_rmii_rx_align.sv
module test_rmii_rx_align;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       speed10_i;
  logic       crs_dv_i;
  logic [1:0] rxd_i;
  logic       wr_valid_o;
  logic [7:0] wr_data_o;
  logic       wr_sof_o;
  logic       wr_eof_o;
  logic       wr_trunc_o;

  always #10 clk = ~clk;

  rmii_rx_align i_rmii_rx_align (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .speed10_i  (speed10_i),
    .crs_dv_i   (crs_dv_i),
    .rxd_i      (rxd_i),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o),
    .wr_sof_o   (wr_sof_o),
    .wr_eof_o   (wr_eof_o),
    .wr_trunc_o (wr_trunc_o)
  );

  int checks = 0;
  int errs   = 0;

  // output monitor
  bit         mon_clr = 1'b0;
  int         cap_n, eof_n, trunc_n, sof_n;
  logic [7:0] cap [16];
  logic       cap_sof [16];

  always @(negedge clk) begin
    if (mon_clr) begin
      cap_n = 0; eof_n = 0; trunc_n = 0; sof_n = 0;
    end else begin
      if (wr_valid_o) begin
        if (cap_n < 16) begin
          cap[cap_n]     = wr_data_o;
          cap_sof[cap_n] = wr_sof_o;
        end
        cap_n++;
      end
      if (wr_sof_o) sof_n++;
      if (wr_eof_o) begin
        eof_n++;
        if (wr_trunc_o) trunc_n++;
      end
    end
  end

  // {speed10, nbytes, preamble di-bits, payload (byte 0 in [7:0])}
  localparam logic [40:0] VEC [8] = '{
    {1'b0, 3'd4, 5'd28, 32'hA5C33C5A},
    {1'b0, 3'd3, 5'd7,  32'h00D555FF},
    {1'b0, 3'd1, 5'd1,  32'h000000AB},
    {1'b0, 3'd4, 5'd0,  32'h12345678},
    {1'b1, 3'd2, 5'd9,  32'h0000E71B},
    {1'b1, 3'd4, 5'd3,  32'hFEDCBA98},
    {1'b0, 3'd2, 5'd15, 32'h0000D5D5},
    {1'b1, 3'd1, 5'd31, 32'h00000096}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic mon_reset();
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic send_dibit(input logic crs, input logic [1:0] d);
    crs_dv_i = crs;
    rxd_i    = d;
    repeat (speed10_i ? 10 : 1) @(negedge clk);
  endtask

  // 10 Mb/s di-bit that is wrong everywhere except around the sample point
  task automatic send_dibit_noisy(input logic [1:0] d);
    crs_dv_i = 1'b1;
    rxd_i = ~d;
    repeat (3) @(negedge clk);
    rxd_i = d;
    repeat (5) @(negedge clk);
    rxd_i = ~d;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 4; i++) send_dibit(1'b1, b[2*i +: 2]);
  endtask

  task automatic send_head(input int npre);
    for (int i = 0; i < npre; i++) send_dibit(1'b1, 2'b01);
    send_byte(8'hD5);
  endtask

  task automatic send_tail();
    send_dibit(1'b0, 2'b00);
    send_dibit(1'b0, 2'b00);
    repeat (speed10_i ? 30 : 6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errs + 1);
    $finish;
  end

  initial begin
    rst_ni    = 1'b0;
    speed10_i = 1'b0;
    crs_dv_i  = 1'b1;
    rxd_i     = 2'b11;
    repeat (3) @(negedge clk);
    // R1: reset holds outputs low despite active line
    chk("R1 valid", int'(wr_valid_o), 0);
    chk("R1 sof",   int'(wr_sof_o),   0);
    chk("R1 eof",   int'(wr_eof_o),   0);
    chk("R1 trunc", int'(wr_trunc_o), 0);
    crs_dv_i = 1'b0;
    rxd_i    = 2'b00;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // table of frames at both rates
    for (int v = 0; v < 8; v++) begin
      logic [40:0] e;
      int          nb;
      string       tg;
      e  = VEC[v];
      nb = int'(e[39:37]);
      speed10_i = e[40];
      tg = e[40] ? "R5" : "R2";
      repeat (4) @(negedge clk);
      mon_reset();
      send_head(int'(e[36:32]));
      for (int b = 0; b < nb; b++) send_byte(e[8*b +: 8]);
      send_tail();
      chk($sformatf("%s vec%0d count", tg, v), cap_n, nb);
      for (int b = 0; b < nb; b++) begin
        chk($sformatf("%s vec%0d byte%0d", tg, v, b), int'(cap[b]), int'(e[8*b +: 8]));
        chk($sformatf("R9 vec%0d sof%0d", v, b), int'(cap_sof[b]), (b == 0) ? 1 : 0);
      end
      chk($sformatf("R3 vec%0d sof count", v), sof_n, 1);
      chk($sformatf("R6 vec%0d eof", v), eof_n, 1);
      chk($sformatf("R7 vec%0d trunc", v), trunc_n, 0);
    end

    // R7: partial trailing byte
    speed10_i = 1'b0;
    mon_reset();
    send_head(5);
    send_byte(8'h3C);
    send_byte(8'h81);
    send_dibit(1'b1, 2'b10);
    send_dibit(1'b1, 2'b10);
    send_dibit(1'b1, 2'b01);
    send_tail();
    chk("R7 partial count", cap_n, 2);
    chk("R7 partial byte1", int'(cap[1]), 8'h81);
    chk("R7 partial eof",   eof_n, 1);
    chk("R7 partial trunc", trunc_n, 1);

    // R8: carrier drop in the middle of the delimiter clears the search
    mon_reset();
    for (int i = 0; i < 6; i++) send_dibit(1'b1, 2'b01);
    send_dibit(1'b1, 2'b01);
    send_dibit(1'b1, 2'b01);
    send_dibit(1'b0, 2'b00);
    send_dibit(1'b1, 2'b01);
    send_dibit(1'b1, 2'b11);
    send_byte(8'h77);
    send_tail();
    chk("R8 no bytes", cap_n, 0);
    chk("R8 no eof",   eof_n, 0);

    // R6: single low sample inside data is skipped
    mon_reset();
    send_head(4);
    send_dibit(1'b1, 2'b00);
    send_dibit(1'b1, 2'b11);
    send_dibit(1'b0, 2'b11);
    send_dibit(1'b1, 2'b01);
    send_dibit(1'b1, 2'b10);
    send_byte(8'h42);
    send_tail();
    chk("R6 gap count", cap_n, 2);
    chk("R6 gap byte0", int'(cap[0]), 8'h9C);
    chk("R6 gap byte1", int'(cap[1]), 8'h42);
    chk("R6 gap eof",   eof_n, 1);

    // R6/R7: delimiter followed directly by end
    mon_reset();
    send_head(3);
    send_tail();
    chk("R6 empty count", cap_n, 0);
    chk("R6 empty eof",   eof_n, 1);
    chk("R7 empty trunc", trunc_n, 0);

    // R4: byte strobe timing at 100 Mb/s
    mon_reset();
    send_head(2);
    send_byte(8'h5A);
    chk("R4 before", int'(wr_valid_o), 0);
    crs_dv_i = 1'b1;
    rxd_i    = 2'b01;
    @(negedge clk);
    chk("R4 strobe", int'(wr_valid_o), 1);
    chk("R4 data",   int'(wr_data_o), 8'h5A);
    rxd_i = 2'b01;
    @(negedge clk);
    chk("R4 after",  int'(wr_valid_o), 0);
    send_dibit(1'b1, 2'b01);
    send_dibit(1'b1, 2'b01);
    send_tail();
    chk("R4 count", cap_n, 2);
    chk("R4 byte1", int'(cap[1]), 8'h55);

    // R5: 10 Mb/s values away from the sample point are ignored
    speed10_i = 1'b1;
    repeat (4) @(negedge clk);
    mon_reset();
    for (int i = 0; i < 4; i++) send_dibit_noisy(2'b01);
    for (int i = 0; i < 3; i++) send_dibit_noisy(2'b01);
    send_dibit_noisy(2'b11);
    for (int i = 0; i < 4; i++) send_dibit_noisy(2'(8'h6B >> (2*i)));
    for (int i = 0; i < 4; i++) send_dibit_noisy(2'(8'hC4 >> (2*i)));
    send_tail();
    chk("R5 noisy count", cap_n, 2);
    chk("R5 noisy byte0", int'(cap[0]), 8'h6B);
    chk("R5 noisy byte1", int'(cap[1]), 8'hC4);
    chk("R5 noisy eof",   eof_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule